// File: doc/BRIEF.md
# Counter Machine Processor

A small Harvard-style processor that runs programs built from four instructions over a bank of fixed-width counters. The program store is internal and is written word by word through a load port. The counters are written through a preload port and read through a readback port. All of these are used only while the core is idle. A start pulse loads the instruction counter with a chosen address. The core then retires one instruction per clock until it reaches a HALT. At that point it raises a halted flag and keeps its state frozen.

There is no unconditional jump. A program makes one by testing a counter that it keeps at zero. DEC on an empty counter and INC on a full counter both saturate, and each sets a sticky flag. A step counter reports how many instructions ran, counting the HALT itself.

Top module: `cm_core`

## Requirements
- R1: After reset the core is idle. Halted is 0, the instruction counter is 0, the step count is 0, both flags are 0 and every counter reads 0.
- R2: A start pulse while the core is idle does four things. It loads the instruction counter from the start address, clears the step count and both flags, drops halted, and begins execution on the next clock. A start pulse while the core is executing has no effect.
- R3: INC (opcode 2'b00) adds one to the selected counter and advances the instruction counter by one.
- R4: DEC (opcode 2'b01) subtracts one from the selected counter and advances the instruction counter by one.
- R5: JZ (opcode 2'b10) loads the target into the instruction counter when the selected counter is zero. Otherwise it advances the instruction counter by one. JZ leaves the counters unchanged.
- R6: HALT (opcode 2'b11) sets halted. After it, the instruction counter stays at the HALT address and the counters stay frozen until the next start.
- R7: DEC on a counter that holds 0 leaves it at 0 and sets the sticky underflow flag.
- R8: INC on a counter that holds its maximum leaves it at the maximum and sets the sticky overflow flag.
- R9: The step count equals the number of instructions executed since start, including the HALT. For the copy program at addresses 1 to 10, started with counter 2 at 2, the count is 21, and counters 2 and 3 both end at 2.
- R10: Program-store writes and counter preloads take effect only while the core is idle, and are ignored while it executes. Readback is combinational at all times.
- R11: An instruction word holds fields from the most significant bit down. The top 2 bits are the opcode. The next log2(NUM_REGS) bits are the counter index. The low log2(PROG_DEPTH) bits are the jump target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse |
| start_addr_i | input | ADDR_W | First instruction address |
| prog_we_i | input | 1 | Program-store write enable |
| prog_addr_i | input | ADDR_W | Program-store write address |
| prog_data_i | input | INSN_W | Instruction word to store |
| reg_we_i | input | 1 | Counter preload enable |
| reg_waddr_i | input | RIDX_W | Counter preload index |
| reg_wdata_i | input | REG_W | Counter preload value |
| reg_raddr_i | input | RIDX_W | Counter readback index |
| reg_rdata_o | output | REG_W | Counter readback value |
| pc_o | output | ADDR_W | Instruction counter |
| halted_o | output | 1 | HALT reached |
| steps_o | output | STEP_W | Instructions executed since start |
| ovf_o | output | 1 | Sticky overflow flag |
| udf_o | output | 1 | Sticky underflow flag |

## Verification
The assertions assume three things about the inputs. Loads arrive only while the core is idle. Reset is held long enough to clear every counter. Each program ends in a HALT that the core can reach, so the step count never wraps during a run. The random programs hold to the last point by construction. Every JZ target points strictly forward and the last word is a HALT, so each run ends within the length of the program. Preload values are biased toward 0 and the maximum so that both saturation paths fire. Load writes made during a run fall only on a long copy program, so the core is always executing when they arrive.

// File: rtl/cm_pkg.sv
package cm_pkg;
  localparam int OP_W = 2;
  typedef enum logic [OP_W-1:0] {
    OP_INC  = 2'b00,
    OP_DEC  = 2'b01,
    OP_JZ   = 2'b10,
    OP_HALT = 2'b11
  } cm_op_e;
endpackage

// File: rtl/cm_prog_store.sv
module cm_prog_store #(
  parameter int DEPTH  = 16,
  parameter int WORD_W = 9,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [WORD_W-1:0] rdata_o
);
  logic [WORD_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/cm_counter_bank.sv
module cm_counter_bank #(
  parameter int NUM_REGS = 8,
  parameter int REG_W    = 8,
  localparam int IW      = $clog2(NUM_REGS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_flags_i,
  input  logic             inc_en_i,
  input  logic             dec_en_i,
  input  logic [IW-1:0]    idx_i,
  output logic             zero_o,
  input  logic             ld_we_i,
  input  logic [IW-1:0]    ld_addr_i,
  input  logic [REG_W-1:0] ld_data_i,
  input  logic [IW-1:0]    rd_addr_i,
  output logic [REG_W-1:0] rd_data_o,
  output logic             ovf_o,
  output logic             udf_o
);
  localparam logic [REG_W-1:0] MAX_V = '1;

  logic [REG_W-1:0] cnt_q [NUM_REGS];
  logic [REG_W-1:0] sel_v;
  logic             at_max, at_zero;
  logic             ovf_q, udf_q;

  assign sel_v   = cnt_q[idx_i];
  assign at_max  = (sel_v == MAX_V);
  assign at_zero = (sel_v == '0);
  assign zero_o  = at_zero;
  assign rd_data_o = cnt_q[rd_addr_i];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_cnt
    logic hit;
    assign hit = (idx_i == IW'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  cnt_q[g] <= '0;
      else if (ld_we_i && ld_addr_i == IW'(g))      cnt_q[g] <= ld_data_i;
      else if (inc_en_i && hit && !at_max)          cnt_q[g] <= cnt_q[g] + REG_W'(1);
      else if (dec_en_i && hit && !at_zero)         cnt_q[g] <= cnt_q[g] - REG_W'(1);
    end

    a_r3_inc_adds_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (inc_en_i && hit && cnt_q[g] != MAX_V && !ld_we_i) |=> cnt_q[g] == $past(cnt_q[g]) + REG_W'(1));
    a_r4_dec_subs_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dec_en_i && hit && cnt_q[g] != '0 && !ld_we_i) |=> cnt_q[g] == $past(cnt_q[g]) - REG_W'(1));
    a_r7_dec_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dec_en_i && hit && cnt_q[g] == '0 && !ld_we_i) |=> (cnt_q[g] == '0) && udf_q);
    a_r8_inc_ceiling: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (inc_en_i && hit && cnt_q[g] == MAX_V && !ld_we_i) |=> (cnt_q[g] == MAX_V) && ovf_q);
    a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!inc_en_i && !dec_en_i && !(ld_we_i && ld_addr_i == IW'(g))) |=> $stable(cnt_q[g]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_q <= 1'b0;
      udf_q <= 1'b0;
    end else if (clr_flags_i) begin
      ovf_q <= 1'b0;
      udf_q <= 1'b0;
    end else begin
      if (inc_en_i && at_max)  ovf_q <= 1'b1;
      if (dec_en_i && at_zero) udf_q <= 1'b1;
    end
  end

  assign ovf_o = ovf_q;
  assign udf_o = udf_q;
endmodule

// File: rtl/cm_sequencer.sv
module cm_sequencer
  import cm_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int STEP_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  cm_op_e            op_i,
  input  logic [ADDR_W-1:0] tgt_i,
  input  logic              zero_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic              running_o,
  output logic              halted_o,
  output logic [STEP_W-1:0] steps_o,
  output logic              clr_o
);
  logic [ADDR_W-1:0] pc_q;
  logic              run_q, halt_q;
  logic [STEP_W-1:0] steps_q;
  logic              launch;

  assign launch = start_i && !run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q    <= '0;
      run_q   <= 1'b0;
      halt_q  <= 1'b0;
      steps_q <= '0;
    end else if (launch) begin
      pc_q    <= start_addr_i;
      run_q   <= 1'b1;
      halt_q  <= 1'b0;
      steps_q <= '0;
    end else if (run_q) begin
      steps_q <= steps_q + STEP_W'(1);
      unique case (op_i)
        OP_HALT: begin
          run_q  <= 1'b0;
          halt_q <= 1'b1;
        end
        OP_JZ:   pc_q <= zero_i ? tgt_i : pc_q + ADDR_W'(1);
        default: pc_q <= pc_q + ADDR_W'(1);
      endcase
    end
  end

  assign pc_o      = pc_q;
  assign running_o = run_q;
  assign halted_o  = halt_q;
  assign steps_o   = steps_q;
  assign clr_o     = launch;

  a_r2_start_loads_pc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch |=> run_q && !halt_q && pc_q == $past(start_addr_i) && steps_q == '0);
  a_r5_jz_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && op_i == OP_JZ && zero_i) |=> pc_q == $past(tgt_i));
  a_r5_jz_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && op_i == OP_JZ && !zero_i) |=> pc_q == $past(pc_q) + ADDR_W'(1));
  a_r6_halt_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_q && !start_i) |=> halt_q && $stable(pc_q) && $stable(steps_q));
  a_r6_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(run_q && halt_q));
  a_r9_step_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |=> steps_q == $past(steps_q) + STEP_W'(1));
endmodule

// File: rtl/cm_core.sv
module cm_core
  import cm_pkg::*;
#(
  parameter int NUM_REGS   = 8,
  parameter int REG_W      = 8,
  parameter int PROG_DEPTH = 16,
  parameter int STEP_W     = 16,
  localparam int ADDR_W    = $clog2(PROG_DEPTH),
  localparam int RIDX_W    = $clog2(NUM_REGS),
  localparam int INSN_W    = OP_W + RIDX_W + ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              prog_we_i,
  input  logic [ADDR_W-1:0] prog_addr_i,
  input  logic [INSN_W-1:0] prog_data_i,
  input  logic              reg_we_i,
  input  logic [RIDX_W-1:0] reg_waddr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  input  logic [RIDX_W-1:0] reg_raddr_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic              halted_o,
  output logic [STEP_W-1:0] steps_o,
  output logic              ovf_o,
  output logic              udf_o
);
  logic [INSN_W-1:0] insn;
  cm_op_e            op;
  logic [RIDX_W-1:0] ridx;
  logic [ADDR_W-1:0] tgt, pc;
  logic              running, zero, clr;

  // R11 field layout: opcode | counter index | target
  assign op   = cm_op_e'(insn[INSN_W-1 -: OP_W]);
  assign ridx = insn[ADDR_W +: RIDX_W];
  assign tgt  = insn[ADDR_W-1:0];

  cm_prog_store #(.DEPTH(PROG_DEPTH), .WORD_W(INSN_W)) i_store (
    .clk_i   (clk_i),
    .we_i    (prog_we_i && !running),
    .waddr_i (prog_addr_i),
    .wdata_i (prog_data_i),
    .raddr_i (pc),
    .rdata_o (insn)
  );

  cm_counter_bank #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) i_bank (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_flags_i (clr),
    .inc_en_i    (running && op == OP_INC),
    .dec_en_i    (running && op == OP_DEC),
    .idx_i       (ridx),
    .zero_o      (zero),
    .ld_we_i     (reg_we_i && !running),
    .ld_addr_i   (reg_waddr_i),
    .ld_data_i   (reg_wdata_i),
    .rd_addr_i   (reg_raddr_i),
    .rd_data_o   (reg_rdata_o),
    .ovf_o       (ovf_o),
    .udf_o       (udf_o)
  );

  cm_sequencer #(.ADDR_W(ADDR_W), .STEP_W(STEP_W)) i_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .start_addr_i (start_addr_i),
    .op_i         (op),
    .tgt_i        (tgt),
    .zero_i       (zero),
    .pc_o         (pc),
    .running_o    (running),
    .halted_o     (halted_o),
    .steps_o      (steps_o),
    .clr_o        (clr)
  );

  assign pc_o = pc;

  a_r10_no_load_while_running: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running && op == OP_JZ) |=> $stable(reg_rdata_o) || $changed(reg_raddr_i));
endmodule

// File: tb/test_cm_core.sv
module test_cm_core;
  localparam int NR = 8, RW = 8, PD = 16, SW = 16;
  localparam int AW = $clog2(PD), IW = $clog2(NR), WW = 2 + IW + AW;
  localparam logic [1:0] INC = 2'b00, DEC = 2'b01, JZ = 2'b10, HLT = 2'b11;

  logic clk = 0, rst_n = 0;
  logic start = 0, pwe = 0, rwe = 0;
  logic [AW-1:0] saddr = '0, paddr = '0;
  logic [WW-1:0] pdata = '0;
  logic [IW-1:0] rwa = '0, rra = '0;
  logic [RW-1:0] rwd = '0;
  logic [RW-1:0] rrd;
  logic [AW-1:0] pc;
  logic halted, ovf, udf;
  logic [SW-1:0] steps;

  int errors = 0, checks = 0, cyc = 0;
  logic [WW-1:0] m_prog [PD];
  int m_regs [NR];
  int e_steps, e_pc, e_ovf, e_udf;

  always #4 clk = ~clk;

  cm_core #(.NUM_REGS(NR), .REG_W(RW), .PROG_DEPTH(PD), .STEP_W(SW)) i_cm_core (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .start_addr_i(saddr),
    .prog_we_i(pwe), .prog_addr_i(paddr), .prog_data_i(pdata),
    .reg_we_i(rwe), .reg_waddr_i(rwa), .reg_wdata_i(rwd),
    .reg_raddr_i(rra), .reg_rdata_o(rrd), .pc_o(pc), .halted_o(halted),
    .steps_o(steps), .ovf_o(ovf), .udf_o(udf));

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog: act=%0d exp<=150000 cycles", cyc);
      finish_run();
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic logic [WW-1:0] mk(logic [1:0] op, int r, int t);
    return {op, IW'(r), AW'(t)};
  endfunction

  task automatic load_word(int a, logic [WW-1:0] w);
    @(negedge clk); pwe = 1; paddr = AW'(a); pdata = w;
    @(negedge clk); pwe = 0;
  endtask

  task automatic load_prog();
    for (int a = 0; a < PD; a++) load_word(a, m_prog[a]);
  endtask

  task automatic preload(int r, int v);
    @(negedge clk); rwe = 1; rwa = IW'(r); rwd = RW'(v);
    @(negedge clk); rwe = 0;
    m_regs[r] = v;
  endtask

  // reference model from R3..R9
  task automatic model_run(int sa);
    int p, r, t;
    logic [1:0] op;
    p = sa; e_steps = 0; e_ovf = 0; e_udf = 0;
    while (e_steps < 5000) begin
      op = m_prog[p][WW-1 -: 2];
      r  = int'(m_prog[p][AW +: IW]);
      t  = int'(m_prog[p][AW-1:0]);
      e_steps++;
      if (op == HLT) break;
      case (op)
        INC: begin if (m_regs[r] == (1<<RW)-1) e_ovf = 1; else m_regs[r]++; p = (p+1) % PD; end
        DEC: begin if (m_regs[r] == 0) e_udf = 1; else m_regs[r]--; p = (p+1) % PD; end
        default: p = (m_regs[r] == 0) ? t : (p+1) % PD;
      endcase
    end
    e_pc = p;
  endtask

  task automatic launch(int sa);
    @(negedge clk); saddr = AW'(sa); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic wait_halt();
    int n = 0;
    while (!halted && n < 6000) begin @(negedge clk); n++; end
    chk("R6 halted reached", int'(halted), 1);
  endtask

  task automatic read_reg(int r, output int v);
    @(negedge clk); rra = IW'(r); #1 v = int'(rrd);
  endtask

  task automatic compare_all(string tag);
    int v;
    for (int r = 0; r < NR; r++) begin
      read_reg(r, v);
      chk({tag, " R3/R4 counter"}, v, m_regs[r]);
    end
    chk({tag, " R9 steps"}, int'(steps), e_steps);
    chk({tag, " R6 pc"}, int'(pc), e_pc);
    chk({tag, " R8 ovf"}, int'(ovf), e_ovf);
    chk({tag, " R7 udf"}, int'(udf), e_udf);
  endtask

  task automatic copy_prog();
    for (int a = 0; a < PD; a++) m_prog[a] = mk(HLT, 0, 0);
    m_prog[1] = mk(JZ, 2, 6);  m_prog[2] = mk(DEC, 2, 0);
    m_prog[3] = mk(INC, 3, 0); m_prog[4] = mk(INC, 1, 0);
    m_prog[5] = mk(JZ, 0, 1);  m_prog[6] = mk(JZ, 1, 10);
    m_prog[7] = mk(DEC, 1, 0); m_prog[8] = mk(INC, 2, 0);
    m_prog[9] = mk(JZ, 0, 6);  m_prog[10] = mk(HLT, 0, 0);
  endtask

  initial begin
    int v, pc_hold, len;
    void'($urandom(32'h00c0ffee));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 halted", int'(halted), 0);
    chk("R1 pc", int'(pc), 0);
    chk("R1 steps", int'(steps), 0);
    chk("R1 ovf", int'(ovf), 0);
    chk("R1 udf", int'(udf), 0);
    for (int r = 0; r < NR; r++) begin read_reg(r, v); chk("R1 counter", v, 0); end

    // R9 copy program, value 2
    copy_prog(); load_prog();
    for (int r = 0; r < NR; r++) preload(r, 0);
    preload(2, 2);
    launch(1);
    chk("R2 running not halted", int'(halted), 0);
    wait_halt();
    chk("R9 copy steps", int'(steps), 21);
    read_reg(2, v); chk("R9 copy r2", v, 2);
    read_reg(3, v); chk("R9 copy r3", v, 2);
    model_run(1);
    chk("R9 model agrees", e_steps, 21);
    pc_hold = int'(pc);
    chk("R6 pc at halt", pc_hold, 10);
    repeat (5) @(negedge clk);
    chk("R6 pc frozen", int'(pc), pc_hold);
    chk("R6 steps frozen", int'(steps), 21);

    // R10: loads during a run are ignored; R2: start while running ignored
    for (int r = 0; r < NR; r++) preload(r, 0);
    preload(2, 6); preload(5, 7);
    launch(1);
    @(negedge clk); rwe = 1; rwa = 3'd5; rwd = 8'd99;
    pwe = 1; paddr = 4'd10; pdata = mk(INC, 4, 0);
    start = 1; saddr = 4'd0;
    @(negedge clk); rwe = 0; pwe = 0; start = 0;
    wait_halt();
    model_run(1);
    compare_all("R10 load during run");
    read_reg(5, v); chk("R10 preload ignored", v, 7);
    chk("R2 start ignored steps", int'(steps), 9*6+3);

    // R7/R8 saturation corners
    for (int a = 0; a < PD; a++) m_prog[a] = mk(HLT, 0, 0);
    m_prog[0] = mk(INC, 4, 0); m_prog[1] = mk(DEC, 6, 0);
    m_prog[2] = mk(INC, 4, 0); m_prog[3] = mk(JZ, 6, 7);
    load_prog();
    for (int r = 0; r < NR; r++) preload(r, 0);
    preload(4, 254);
    launch(0); wait_halt();
    model_run(0);
    compare_all("R7/R8 corner");
    read_reg(4, v); chk("R8 saturate max", v, 255);
    read_reg(6, v); chk("R7 stays zero", v, 0);
    chk("R5 jz taken target", int'(pc), 7);

    // R2: new start clears flags
    for (int a = 0; a < PD; a++) m_prog[a] = mk(HLT, 0, 0);
    load_prog();
    launch(0); wait_halt();
    chk("R2 flags cleared ovf", int'(ovf), 0);
    chk("R2 flags cleared udf", int'(udf), 0);
    chk("R6 halt only step", int'(steps), 1);

    // random forward-only programs, R3 R4 R5 R11
    for (int n = 0; n < 40; n++) begin
      len = 3 + int'($urandom % 13);
      for (int a = 0; a < PD; a++) m_prog[a] = mk(HLT, 0, 0);
      for (int a = 0; a < len - 1; a++) begin
        case ($urandom % 3)
          0: m_prog[a] = mk(INC, int'($urandom % NR), 0);
          1: m_prog[a] = mk(DEC, int'($urandom % NR), 0);
          default: m_prog[a] = mk(JZ, int'($urandom % NR),
                                  a + 1 + int'($urandom % (len - 1 - a)));
        endcase
      end
      load_prog();
      for (int r = 0; r < NR; r++) begin
        case ($urandom % 5)
          0: preload(r, 0);
          1: preload(r, 1);
          2: preload(r, 254);
          3: preload(r, 255);
          default: preload(r, int'($urandom % 256));
        endcase
      end
      launch(0); wait_halt();
      model_run(0);
      compare_all("R5 random");
    end
    finish_run();
  end
endmodule